// File: doc/BRIEF.md
# Dual-Converter Lockstep Sequence Controller

This block drives two analog converters, a leading one and a following one, through a regular conversion sequence in lockstep. A single start strobe launches both converters on every step, and a step counts as finished when the leading converter reports done, because the following converter always needs less time. Each finished step sets a shared result-valid flag. The last step of the sequence raises a one-clock end-of-sequence pulse and wraps the step index back to zero.

Two options shape the pacing. Discontinuous operation cuts the sequence into groups of a programmable size, and each group waits for its own trigger. Auto-delay operation holds every following step until the shared result has been read. It also refuses a new sequence trigger after the end until that read has happened. In every mode, triggers that arrive while a sequence is running or stalled are dropped. They are not queued.

A configuration guard blocks triggers when the two converters are programmed with different step counts, or when auto-delay is combined with a DMA setting that cannot keep up. It also rejects any request to use injected channels while auto-delay is enabled.

The controller has six states:
- `ST_IDLE`: waits for a sequence trigger.
- `ST_LAUNCH`: issues the start strobe.
- `ST_CONV`: waits for the leading converter's done.
- `ST_HOLD`: the auto-delay stall between steps.
- `ST_GAP`: waits for the trigger of the next discontinuous group.
- `ST_DRAIN`: the auto-delay stall after the last step.

The transitions are:
- `ST_IDLE`→`ST_LAUNCH` on an accepted trigger.
- `ST_LAUNCH`→`ST_CONV` always.
- `ST_CONV`→`ST_IDLE` when the last step is done without auto-delay.
- `ST_CONV`→`ST_DRAIN` when the last step is done with auto-delay.
- `ST_CONV`→`ST_HOLD` when any other step is done with auto-delay.
- `ST_CONV`→`ST_GAP` when a group closes in discontinuous operation.
- `ST_CONV`→`ST_LAUNCH` otherwise.
- `ST_HOLD`→`ST_GAP` or `ST_LAUNCH` on a read. It goes to `ST_GAP` when the step just finished closed a discontinuous group.
- `ST_GAP`→`ST_LAUNCH` on an accepted trigger.
- `ST_DRAIN`→`ST_IDLE` on a read.

Top module: `dual_sim_seq_ctrl`

## Requirements
- R1: After reset, `start_o`, `eos_o`, `res_valid_o` and `step_o` are all 0, and the controller is idle.
- R2: A trigger sampled while idle, with no configuration error, raises `start_o` for exactly one clock, in the cycle after the sampling edge. `step_o` reads 0 during that pulse.
- R3: A leading-converter done sampled in `ST_CONV` completes the step. `res_valid_o` is 1 in the following cycle. Without auto-delay and outside a group boundary, the next start with `step_o` one higher follows in that same cycle.
- R4: When the last step completes (index equal to `m_len_i`, so a sequence has `m_len_i`+1 steps, 1 to 16), `eos_o` is high for exactly one clock in the next cycle. `step_o` reads 0 at that point, and the controller returns to idle, or to `ST_DRAIN` under auto-delay.
- R5: A trigger that arrives while a sequence is launching, converting or stalled produces no start. It is not remembered later.
- R6: With `disc_en_i` = 1, after every `disc_num_i`+1 completed steps that do not end the sequence, the controller waits in `ST_GAP`. The next start comes one cycle after the next accepted trigger.
- R7: With `auto_dly_i` = 1, after a step that does not end the sequence, no start is issued until `rd_shared_i` or `rd_master_i` is sampled high. The next start follows one cycle after that read.
- R8: With `auto_dly_i` = 1, after the end of a sequence, triggers are ignored until a read is sampled. A trigger after that read is accepted.
- R9: `cfg_err_o` is 1 in the same cycle whenever `m_len_i` differs from `s_len_i`. While it is 1, triggers in `ST_IDLE` or `ST_GAP` produce no start.
- R10: `cfg_err_o` is 1 when `auto_dly_i` = 1, `dma_en_i` = 1 and `dma_mode_i` is 2'b00 or 2'b01. The settings 2'b10 and 2'b11 are allowed.
- R11: `inj_rej_o` is 1 exactly while `inj_req_i` = 1 and `auto_dly_i` = 1.
- R12: A read with no step completing in the same cycle clears `res_valid_o` in the next cycle. A step completion in the same cycle as a read leaves it set.
- R13: The discontinuous group count restarts at the end of every sequence. The first group of a new sequence is always a full `disc_num_i`+1 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Regular trigger event |
| m_len_i | input | STEP_W | Leading converter step count minus one |
| s_len_i | input | STEP_W | Following converter step count minus one |
| disc_en_i | input | 1 | Discontinuous grouping enable |
| disc_num_i | input | STEP_W | Group size minus one |
| auto_dly_i | input | 1 | Auto-delay enable |
| dma_en_i | input | 1 | DMA servicing enabled |
| dma_mode_i | input | 2 | DMA transfer mode |
| inj_req_i | input | 1 | Request to use injected channels |
| m_done_i | input | 1 | Leading converter done |
| rd_shared_i | input | 1 | Shared result register read |
| rd_master_i | input | 1 | Leading converter result register read |
| start_o | output | 1 | Start strobe to both converters |
| step_o | output | STEP_W | Index of the current step |
| res_valid_o | output | 1 | Shared result valid |
| eos_o | output | 1 | End-of-sequence pulse |
| cfg_err_o | output | 1 | Configuration error, triggers blocked |
| inj_rej_o | output | 1 | Injected-channel request rejected |

## Verification
Registered results are due one clock after their cause is sampled:
- A start strobe follows an accepted trigger or an unblocking read.
- A start strobe, result-valid and the end-of-sequence pulse follow a done.

The configuration flags are combinational and valid in the same cycle. The driver works from the cycle count at the edge where it applies a stimulus. It pushes each expected start or end event, with its step index and due cycle, into a queue, and the monitor pops the queue on every event it sees at a falling edge. An event that arrives with no entry waiting fails, which is how the dropped triggers are checked. Level checks on result-valid and the configuration flags are sampled at the falling edge after the stimulus.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LAUNCH = 3'd1,
        ST_CONV   = 3'd2,
        ST_HOLD   = 3'd3,
        ST_GAP    = 3'd4,
        ST_DRAIN  = 3'd5
    } dsc_state_e;

    localparam logic [1:0] DMA_MODE_FAST_BIT = 2'b10;

endpackage

// File: rtl/dsc_cfg_guard.sv
module dsc_cfg_guard #(
    parameter int STEP_W = 4
) (
    input  logic [STEP_W-1:0] m_len_i,
    input  logic [STEP_W-1:0] s_len_i,
    input  logic              auto_dly_i,
    input  logic              dma_en_i,
    input  logic [1:0]        dma_mode_i,
    input  logic              inj_req_i,
    output logic              len_err_o,
    output logic              dma_err_o,
    output logic              inj_rej_o
);
    // Step counts of the two converters must agree for lockstep operation.
    assign len_err_o = (m_len_i != s_len_i);

    // Auto-delay with DMA needs one of the multi-transfer modes (upper bit set).
    assign dma_err_o = auto_dly_i && dma_en_i
                       && ((dma_mode_i & dsc_pkg::DMA_MODE_FAST_BIT) == 2'b00);

    // Injected channels are not allowed together with auto-delay.
    assign inj_rej_o = inj_req_i && auto_dly_i;
endmodule

// File: rtl/dsc_step_track.sv
module dsc_step_track #(
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic [STEP_W-1:0] len_i,
    input  logic [STEP_W-1:0] grp_len_i,
    output logic [STEP_W-1:0] step_o,
    output logic              last_o,
    output logic              grp_end_o,
    output logic              grp_zero_o
);
    localparam logic [STEP_W-1:0] ONE = {{(STEP_W-1){1'b0}}, 1'b1};

    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] grp_q;

    assign step_o     = step_q;
    assign last_o     = (step_q == len_i);
    assign grp_end_o  = (grp_q == grp_len_i);
    assign grp_zero_o = (grp_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= '0;
            grp_q  <= '0;
        end else if (adv_i) begin
            if (last_o) begin
                // End of sequence: both counters restart.
                step_q <= '0;
                grp_q  <= '0;
            end else begin
                step_q <= step_q + ONE;
                grp_q  <= grp_end_o ? '0 : (grp_q + ONE);
            end
        end
    end
endmodule

// File: rtl/dsc_flags.sv
module dsc_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic eos_set_i,
    output logic valid_o,
    output logic eos_o
);
    logic valid_q;
    logic eos_q;

    assign valid_o = valid_q;
    assign eos_o   = eos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            eos_q   <= 1'b0;
        end else begin
            // A fresh result beats a read in the same cycle.
            if (set_i) begin
                valid_q <= 1'b1;
            end else if (clr_i) begin
                valid_q <= 1'b0;
            end
            eos_q <= eos_set_i;
        end
    end
endmodule

// File: rtl/dual_sim_seq_ctrl.sv
module dual_sim_seq_ctrl #(
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic [STEP_W-1:0] m_len_i,
    input  logic [STEP_W-1:0] s_len_i,
    input  logic              disc_en_i,
    input  logic [STEP_W-1:0] disc_num_i,
    input  logic              auto_dly_i,
    input  logic              dma_en_i,
    input  logic [1:0]        dma_mode_i,
    input  logic              inj_req_i,
    input  logic              m_done_i,
    input  logic              rd_shared_i,
    input  logic              rd_master_i,
    output logic              start_o,
    output logic [STEP_W-1:0] step_o,
    output logic              res_valid_o,
    output logic              eos_o,
    output logic              cfg_err_o,
    output logic              inj_rej_o
);
    import dsc_pkg::*;

    dsc_state_e state_q;
    dsc_state_e state_d;

    logic len_err;
    logic dma_err;
    logic rd_any;
    logic trig_ok;
    logic step_done;
    logic eos_set;
    logic last_step;
    logic grp_end;
    logic grp_zero;

    dsc_cfg_guard #(.STEP_W(STEP_W)) u_guard (
        .m_len_i   (m_len_i),
        .s_len_i   (s_len_i),
        .auto_dly_i(auto_dly_i),
        .dma_en_i  (dma_en_i),
        .dma_mode_i(dma_mode_i),
        .inj_req_i (inj_req_i),
        .len_err_o (len_err),
        .dma_err_o (dma_err),
        .inj_rej_o (inj_rej_o)
    );

    dsc_step_track #(.STEP_W(STEP_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv_i     (step_done),
        .len_i     (m_len_i),
        .grp_len_i (disc_num_i),
        .step_o    (step_o),
        .last_o    (last_step),
        .grp_end_o (grp_end),
        .grp_zero_o(grp_zero)
    );

    dsc_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (step_done),
        .clr_i    (rd_any),
        .eos_set_i(eos_set),
        .valid_o  (res_valid_o),
        .eos_o    (eos_o)
    );

    assign cfg_err_o = len_err || dma_err;
    assign rd_any    = rd_shared_i || rd_master_i;
    assign trig_ok   = trig_i && !cfg_err_o;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (trig_ok) state_d = ST_LAUNCH;
            end
            ST_LAUNCH: begin
                state_d = ST_CONV;
            end
            ST_CONV: begin
                if (m_done_i) begin
                    if (last_step) begin
                        state_d = auto_dly_i ? ST_DRAIN : ST_IDLE;
                    end else if (auto_dly_i) begin
                        state_d = ST_HOLD;
                    end else if (disc_en_i && grp_end) begin
                        state_d = ST_GAP;
                    end else begin
                        state_d = ST_LAUNCH;
                    end
                end
            end
            ST_HOLD: begin
                // The group counter was already restarted if the step closed a group.
                if (rd_any) begin
                    state_d = (disc_en_i && grp_zero) ? ST_GAP : ST_LAUNCH;
                end
            end
            ST_GAP: begin
                if (trig_ok) state_d = ST_LAUNCH;
            end
            ST_DRAIN: begin
                if (rd_any) state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Output logic
    always_comb begin
        start_o   = (state_q == ST_LAUNCH);
        step_done = (state_q == ST_CONV) && m_done_i;
        eos_set   = step_done && last_step;
    end
endmodule

// File: rtl/dual_sim_seq_ctrl_chk.sv
module dual_sim_seq_ctrl_chk #(
    parameter int STEP_W = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input dsc_pkg::dsc_state_e  state_q,
    input logic                 m_done_i,
    input logic                 rd_shared_i,
    input logic                 rd_master_i,
    input logic                 start_o,
    input logic                 eos_o,
    input logic [STEP_W-1:0]    step_o,
    input logic                 res_valid_o,
    input logic                 cfg_err_o
);
    import dsc_pkg::*;

    // R2
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    // R3
    valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid_o) |-> $past(m_done_i));

    // R4
    eos_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eos_o |=> !eos_o);

    // R4
    eos_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eos_o |-> (step_o == '0));

    // R5
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV && !m_done_i) |=> !start_o);

    // R7
    hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !rd_shared_i && !rd_master_i) |=> !start_o);

    // R8
    drain_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && !rd_shared_i && !rd_master_i)
        |=> (state_q == ST_DRAIN));

    // R9
    cfg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE || state_q == ST_GAP) && cfg_err_o) |=> !start_o);

    // R12
    valid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_shared_i || rd_master_i) && !(state_q == ST_CONV && m_done_i))
        |=> !res_valid_o);
endmodule

bind dual_sim_seq_ctrl dual_sim_seq_ctrl_chk #(.STEP_W(STEP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .m_done_i   (m_done_i),
    .rd_shared_i(rd_shared_i),
    .rd_master_i(rd_master_i),
    .start_o    (start_o),
    .eos_o      (eos_o),
    .step_o     (step_o),
    .res_valid_o(res_valid_o),
    .cfg_err_o  (cfg_err_o)
);

// File: tb/dual_sim_seq_ctrl_bench.sv
`timescale 1ns/1ps
module dual_sim_seq_ctrl_bench;
    localparam int STEP_W = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n;
    logic              trig_i;
    logic [STEP_W-1:0] m_len_i;
    logic [STEP_W-1:0] s_len_i;
    logic              disc_en_i;
    logic [STEP_W-1:0] disc_num_i;
    logic              auto_dly_i;
    logic              dma_en_i;
    logic [1:0]        dma_mode_i;
    logic              inj_req_i;
    logic              m_done_i;
    logic              rd_shared_i;
    logic              rd_master_i;
    logic              start_o;
    logic [STEP_W-1:0] step_o;
    logic              res_valid_o;
    logic              eos_o;
    logic              cfg_err_o;
    logic              inj_rej_o;

    dual_sim_seq_ctrl #(.STEP_W(STEP_W)) u_dual_sim_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i),
        .m_len_i(m_len_i), .s_len_i(s_len_i),
        .disc_en_i(disc_en_i), .disc_num_i(disc_num_i),
        .auto_dly_i(auto_dly_i), .dma_en_i(dma_en_i), .dma_mode_i(dma_mode_i),
        .inj_req_i(inj_req_i), .m_done_i(m_done_i),
        .rd_shared_i(rd_shared_i), .rd_master_i(rd_master_i),
        .start_o(start_o), .step_o(step_o), .res_valid_o(res_valid_o),
        .eos_o(eos_o), .cfg_err_o(cfg_err_o), .inj_rej_o(inj_rej_o)
    );

    typedef enum int {EV_START = 1, EV_EOS = 2} ev_e;
    typedef struct {
        ev_e   kind;
        int    step;
        int    cyc;
        string req;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 0;

    always @(posedge clk) cyc++;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic seen(ev_e k);
        exp_t e;
        if (sb.size() == 0) begin
            check(1'b0, "R5", "unexpected event kind", int'(k), 0);
        end else begin
            e = sb.pop_front();
            n_chk++;
            if (e.kind != k || e.step != int'(step_o) || e.cyc != cyc) begin
                n_fail++;
                $display("FAIL %s event: actual kind=%0d step=%0d cyc=%0d expected kind=%0d step=%0d cyc=%0d",
                         e.req, int'(k), step_o, cyc, int'(e.kind), e.step, e.cyc);
            end
        end
    endtask

    // Monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (start_o) seen(EV_START);
            if (eos_o)   seen(EV_EOS);
        end
    end

    // Driver tasks
    task automatic fire_trig(bit accepted, int step, string req);
        @(negedge clk);
        trig_i = 1'b1;
        if (accepted) sb.push_back('{EV_START, step, cyc + 1, req});
        @(negedge clk);
        trig_i = 1'b0;
    endtask

    // kind: 0 no event, 1 next start, 2 end of sequence
    task automatic fire_done(int kind, int step, string req, bit with_rd);
        @(negedge clk);
        m_done_i    = 1'b1;
        rd_shared_i = with_rd;
        if (kind == 1) sb.push_back('{EV_START, step, cyc + 1, req});
        if (kind == 2) sb.push_back('{EV_EOS, 0, cyc + 1, req});
        @(negedge clk);
        m_done_i    = 1'b0;
        rd_shared_i = 1'b0;
        check(res_valid_o == 1'b1, "R3", "res_valid after done", res_valid_o, 1);
    endtask

    task automatic fire_rd(bit master, bit exp_start, int step, string req);
        @(negedge clk);
        if (master) rd_master_i = 1'b1; else rd_shared_i = 1'b1;
        if (exp_start) sb.push_back('{EV_START, step, cyc + 1, req});
        @(negedge clk);
        rd_master_i = 1'b0;
        rd_shared_i = 1'b0;
        check(res_valid_o == 1'b0, "R12", "res_valid after read", res_valid_o, 0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            check(1'b0, "R1", "watchdog expired", cyc, 0);
            summary();
        end
    end

    initial begin
        rst_n = 0; trig_i = 0; m_len_i = 4'd2; s_len_i = 4'd2;
        disc_en_i = 0; disc_num_i = 4'd0; auto_dly_i = 0; dma_en_i = 0;
        dma_mode_i = 2'b00; inj_req_i = 0; m_done_i = 0;
        rd_shared_i = 0; rd_master_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(start_o == 0, "R1", "start_o", start_o, 0);
        check(eos_o == 0, "R1", "eos_o", eos_o, 0);
        check(res_valid_o == 0, "R1", "res_valid_o", res_valid_o, 0);
        check(step_o == 0, "R1", "step_o", step_o, 0);

        // Plain three-step sequence: R2, R3, R5, R12, R4
        fire_trig(1, 0, "R2");
        fire_trig(0, 0, "R5");
        fire_done(1, 1, "R3", 0);
        fire_done(1, 2, "R12", 1);
        check(res_valid_o == 1, "R12", "set wins over read", res_valid_o, 1);
        fire_done(2, 0, "R4", 0);
        repeat (2) @(negedge clk);
        fire_rd(0, 0, 0, "R12");

        // One-step sequence boundary: R4
        m_len_i = 4'd0; s_len_i = 4'd0;
        fire_trig(1, 0, "R2");
        fire_done(2, 0, "R4", 0);

        // Discontinuous groups of two in three steps: R6, R13
        m_len_i = 4'd2; s_len_i = 4'd2; disc_en_i = 1; disc_num_i = 4'd1;
        fire_trig(1, 0, "R6");
        fire_done(1, 1, "R6", 0);
        fire_done(0, 0, "R6", 0);
        repeat (4) @(negedge clk);
        fire_trig(1, 2, "R6");
        fire_done(2, 0, "R4", 0);
        fire_trig(1, 0, "R13");
        fire_done(1, 1, "R13", 0);
        fire_done(0, 0, "R13", 0);
        repeat (2) @(negedge clk);
        fire_trig(1, 2, "R6");
        fire_done(2, 0, "R4", 0);
        disc_en_i = 0; disc_num_i = 4'd0;

        // Auto-delay, two steps: R7, R8
        m_len_i = 4'd1; s_len_i = 4'd1; auto_dly_i = 1;
        fire_trig(1, 0, "R7");
        fire_done(0, 0, "R7", 0);
        repeat (3) @(negedge clk);
        fire_trig(0, 0, "R5");
        fire_rd(0, 1, 1, "R7");
        fire_done(2, 0, "R4", 0);
        fire_trig(0, 0, "R8");
        repeat (2) @(negedge clk);
        fire_rd(1, 0, 0, "R8");
        fire_trig(1, 0, "R8");
        fire_done(0, 0, "R7", 0);
        fire_rd(1, 1, 1, "R7");
        fire_done(2, 0, "R4", 0);
        fire_rd(0, 0, 0, "R8");
        auto_dly_i = 0;

        // Step count mismatch: R9
        @(negedge clk);
        m_len_i = 4'd2; s_len_i = 4'd3;
        #1 check(cfg_err_o == 1, "R9", "cfg_err on mismatch", cfg_err_o, 1);
        fire_trig(0, 0, "R9");
        repeat (3) @(negedge clk);
        s_len_i = 4'd2;
        #1 check(cfg_err_o == 0, "R9", "cfg_err cleared", cfg_err_o, 0);

        // DMA mode rule: R10
        @(negedge clk);
        auto_dly_i = 1; dma_en_i = 1; dma_mode_i = 2'b01;
        #1 check(cfg_err_o == 1, "R10", "cfg_err mode 01", cfg_err_o, 1);
        fire_trig(0, 0, "R10");
        repeat (2) @(negedge clk);
        dma_mode_i = 2'b10;
        #1 check(cfg_err_o == 0, "R10", "cfg_err mode 10", cfg_err_o, 0);
        dma_mode_i = 2'b11;
        #1 check(cfg_err_o == 0, "R10", "cfg_err mode 11", cfg_err_o, 0);
        dma_mode_i = 2'b00; auto_dly_i = 0;
        #1 check(cfg_err_o == 0, "R10", "cfg_err without auto-delay", cfg_err_o, 0);
        dma_en_i = 0;

        // Injected request rejection: R11
        @(negedge clk);
        inj_req_i = 1; auto_dly_i = 1;
        #1 check(inj_rej_o == 1, "R11", "inj_rej with auto-delay", inj_rej_o, 1);
        auto_dly_i = 0;
        #1 check(inj_rej_o == 0, "R11", "inj_rej without auto-delay", inj_rej_o, 0);
        inj_req_i = 0;

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R2", "missing expected events", sb.size(), 0);
        if (!finished) begin
            finished = 1;
            summary();
        end
    end
endmodule